// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream and files them into a ring of buffer descriptors. Descriptors and their payload buffers are held in an internal store. A host port reads and writes descriptor words and reads buffer words. Software sets the ownership bit of a descriptor to hand it to the engine. The engine fills that descriptor's buffer, then writes a status word that carries the length, the kind of destination match and any error flags. Writing the status clears ownership. The engine then steps to the next descriptor in the ring, wrapping from the last entry back to the first.

A frame longer than one buffer continues in the following descriptors. The first descriptor of a frame carries a start flag and the final one an end flag. Some frames cannot be stored because the engine meets a descriptor that the host still owns. Such a frame is discarded, a missed-frame counter counts it, a buffer-unavailable pulse is raised, and the engine stays stalled until a poll strobe finds an owned descriptor. A receive pulse marks each completed frame. The stream has no back-pressure. Address filtering is done upstream, and its result arrives as a 3-bit match code on the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset every descriptor word reads 0 (host-owned), `miss_cnt` is 0, `rx_int`, `bufna_int` and `host_rdata` are 0, and the engine starts at descriptor 0.
- R2: A frame whose first byte meets an engine-owned descriptor (status bit 31 = 1) is stored. Byte k of the buffer sits in buffer word k/4, bits 8*(k%4)+7 down to 8*(k%4). The descriptor's status word is then rewritten with bit 31 = 0.
- R3: The status of a frame held in one buffer has bits 27:16 = number of bytes received (CRC included), bit 11 = 1 (first) and bit 10 = 1 (last). Bits 31:28, 15, 9:8 and 1:0 are 0.
- R4: On the last byte, `rx_match[2]` goes to status bit 14 (multicast), `rx_match[1]` to bit 13 (broadcast) and `rx_match[0]` to bit 12 (own address).
- R5: On the last byte, `rx_err[4:0]` goes to status bits 6:2 (runt, too long, alignment, CRC, receive error, in that order from bit 6). Bit 7 is the OR of those five bits.
- R6: Descriptors are used in the order 0, 1, 2, 3, 0, ...
- R7: A frame longer than 1536 bytes fills one buffer and continues in the next descriptor. The earlier descriptor's status has length 1536, bit 11 = 1, bit 10 = 0, and no match or error bits. The final descriptor's status has the total frame length, bit 11 = 0 and bit 10 = 1.
- R8: `rx_int` is high for one cycle after the status write of a frame's last descriptor. An intermediate descriptor write does not raise it.
- R9: A frame whose first byte meets a host-owned descriptor is discarded whole: no buffer or descriptor is written. `miss_cnt` rises by 1 and the engine stalls. Later frames are discarded and counted, even after the host hands descriptors back, until a poll resumes the engine.
- R10: `bufna_int` pulses for one cycle when the engine stalls, and on each poll made while stalled that still finds a host-owned descriptor. A poll that finds an engine-owned descriptor resumes the engine without a pulse. A poll made while running has no effect.
- R11: A poll in the same cycle as a frame's first byte, while stalled with an engine-owned current descriptor, lets that frame be stored.
- R12: If a frame crosses into a host-owned descriptor, the filled descriptor is written back as non-last. The remainder of the frame is discarded, `miss_cnt` rises by 1, `bufna_int` pulses, the engine stalls and `rx_int` stays low.
- R13: Host reads return data one cycle after the request (`host_dsel` = 1 selects descriptor words, index in the low address bits). Host writes to buffer words have no effect.
- R14: When the host and the engine write the same descriptor in the same cycle, the engine's status word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 5 | Error flags, sampled with the last byte |
| rx_match | input | 3 | Destination match kind, sampled with the last byte |
| poll | input | 1 | Poll strobe: re-check ownership when stalled |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_dsel | input | 1 | 1 selects descriptor words, 0 buffer words |
| host_addr | input | 11 | Word address (descriptor index or buffer word) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the request |
| rx_int | output | 1 | Frame completed pulse |
| bufna_int | output | 1 | Buffer unavailable pulse |
| miss_cnt | output | 16 | Saturating count of discarded frames |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a poll strobe and the first byte of a frame, arriving while the engine is stalled on a descriptor the host has just returned. The bench drives both in one cycle and expects the frame in that descriptor, with no missed frame and no buffer-unavailable pulse. The second pair is a host write and the engine's write-back to the same descriptor. The bench issues the host write in the cycle of a frame's last byte and expects the engine's status word when it reads the descriptor back.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  localparam int DESC_W    = 32;
  localparam int ST_LEN_W  = 12;
  localparam int ERR_W     = 5;
  localparam int MATCH_W   = 3;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,  // between frames
    FS_FILL = 2'd1,  // storing bytes into current buffer
    FS_NEXT = 2'd2,  // frame continues, next descriptor not yet checked
    FS_DROP = 2'd3   // discarding the remainder of a frame
  } fill_state_e;

  // Status word: [31] owner (left 0 by the engine), [27:16] length,
  // [14:12] match kind, [11] first, [10] last, [7] error summary, [6:2] errors.
  function automatic logic [DESC_W-1:0] pack_status(
    input logic [ST_LEN_W-1:0] len,
    input logic [MATCH_W-1:0]  match,
    input logic                first,
    input logic                last,
    input logic [ERR_W-1:0]    err
  );
    logic [DESC_W-1:0] s;
    s        = '0;
    s[27:16] = len;
    s[14:12] = match;
    s[11]    = first;
    s[10]    = last;
    s[7]     = |err;
    s[6:2]   = err;
    return s;
  endfunction
endpackage

// File: rtl/rxr_rst_sync.sv
`timescale 1ns/1ps
module rxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/rxr_desc_store.sv
`timescale 1ns/1ps
module rxr_desc_store import rxr_pkg::*; #(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eng_we,
  input  logic [IDX_W-1:0]    eng_idx,
  input  logic [DESC_W-1:0]   eng_wdata,
  input  logic                host_we,
  input  logic [IDX_W-1:0]    host_idx,
  input  logic [DESC_W-1:0]   host_wdata,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DESC_W-1:0]   rd_data,
  output logic [NUM_DESC-1:0] own_vec
);
  logic [DESC_W-1:0] desc_w [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
    logic [DESC_W-1:0] word_q;
    logic [DESC_W-1:0] word_d;
    logic              word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (host_we && host_idx == IDX_W'(i)) begin
        word_en = 1'b1;
        word_d  = host_wdata;
      end
      // engine write-back takes priority over the host
      if (eng_we && eng_idx == IDX_W'(i)) begin
        word_en = 1'b1;
        word_d  = eng_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign desc_w[i]  = word_q;
    assign own_vec[i] = word_q[DESC_W-1];
  end

  assign rd_data = desc_w[rd_idx];

  AST_ENGINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && host_we && eng_idx == host_idx) |=> desc_w[$past(eng_idx)] == $past(eng_wdata)); // R14
endmodule

// File: rtl/rxr_buf_mem.sv
`timescale 1ns/1ps
module rxr_buf_mem #(
  parameter int DEPTH = 1536,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_lane,
  input  logic [7:0]    wr_byte,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr][{wr_lane, 3'b000} +: 8] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rxr_fill_ctrl.sv
`timescale 1ns/1ps
module rxr_fill_ctrl import rxr_pkg::*; #(
  parameter int NUM_DESC  = 4,
  parameter int IDX_W     = 2,
  parameter int BUF_BYTES = 1536,
  parameter int BOFF_W    = 11,
  parameter int AW        = 11,
  parameter int MISS_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_last,
  input  logic [ERR_W-1:0]    rx_err,
  input  logic [MATCH_W-1:0]  rx_match,
  input  logic                poll,
  input  logic [NUM_DESC-1:0] own_vec,
  output logic                desc_we,
  output logic [IDX_W-1:0]    desc_idx,
  output logic [DESC_W-1:0]   desc_wdata,
  output logic                buf_we,
  output logic [AW-1:0]       buf_addr,
  output logic [1:0]          buf_lane,
  output logic [7:0]          buf_byte,
  output logic                rx_int,
  output logic                bufna_int,
  output logic [MISS_W-1:0]   miss_cnt
);
  localparam int BUF_WORDS = BUF_BYTES / 4;

  fill_state_e         state_q, state_d;
  logic                stalled_q, stalled_d;
  logic [IDX_W-1:0]    ptr_q, ptr_d, ptr_nxt;
  logic [BOFF_W-1:0]   boff_q, boff_d, eff_boff;
  logic [ST_LEN_W-1:0] flen_q, flen_d, eff_flen, new_len;
  logic                first_q, first_d, eff_first;
  logic                rx_int_d, bufna_d, miss_inc, store, run_ok, cur_own;

  assign cur_own = own_vec[ptr_q];
  assign run_ok  = !stalled_q || poll;
  assign ptr_nxt = (ptr_q == IDX_W'(NUM_DESC-1)) ? '0 : ptr_q + 1'b1;
  assign new_len = eff_flen + ST_LEN_W'(1);

  always_comb begin
    state_d    = state_q;
    stalled_d  = stalled_q;
    ptr_d      = ptr_q;
    boff_d     = boff_q;
    flen_d     = flen_q;
    first_d    = first_q;
    rx_int_d   = 1'b0;
    bufna_d    = 1'b0;
    miss_inc   = 1'b0;
    store      = 1'b0;
    eff_boff   = boff_q;
    eff_first  = first_q;
    eff_flen   = flen_q;
    desc_we    = 1'b0;
    desc_wdata = '0;

    // poll strobe only matters while stalled
    if (stalled_q && poll) begin
      if (cur_own) stalled_d = 1'b0;
      else         bufna_d   = 1'b1;
    end

    unique case (state_q)
      FS_IDLE: if (rx_valid) begin
        if (run_ok && cur_own) begin
          store     = 1'b1;
          eff_boff  = '0;
          eff_first = 1'b1;
          eff_flen  = '0;
        end else begin
          miss_inc  = 1'b1;
          stalled_d = 1'b1;
          if (!stalled_q) bufna_d = 1'b1;
          if (!rx_last)   state_d = FS_DROP;
        end
      end
      FS_NEXT: if (rx_valid) begin
        if (cur_own) begin
          store     = 1'b1;
          eff_boff  = '0;
          eff_first = 1'b0;
        end else begin
          miss_inc  = 1'b1;
          stalled_d = 1'b1;
          bufna_d   = 1'b1;
          state_d   = rx_last ? FS_IDLE : FS_DROP;
        end
      end
      FS_FILL: if (rx_valid) store = 1'b1;
      FS_DROP: if (rx_valid && rx_last) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase

    if (store) begin
      flen_d  = new_len;
      first_d = eff_first;
      boff_d  = eff_boff + 1'b1;
      state_d = FS_FILL;
      if (rx_last) begin
        desc_we    = 1'b1;
        desc_wdata = pack_status(new_len, rx_match, eff_first, 1'b1, rx_err);
        ptr_d      = ptr_nxt;
        rx_int_d   = 1'b1;
        state_d    = FS_IDLE;
      end else if (eff_boff == BOFF_W'(BUF_BYTES-1)) begin
        desc_we    = 1'b1;
        desc_wdata = pack_status(new_len, '0, eff_first, 1'b0, '0);
        ptr_d      = ptr_nxt;
        state_d    = FS_NEXT;
      end
    end
  end

  assign desc_idx = ptr_q;
  assign buf_we   = store;
  assign buf_addr = AW'(ptr_q) * AW'(BUF_WORDS) + AW'(eff_boff >> 2);
  assign buf_lane = eff_boff[1:0];
  assign buf_byte = rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FS_IDLE;
      stalled_q <= 1'b0;
      ptr_q     <= '0;
      boff_q    <= '0;
      flen_q    <= '0;
      first_q   <= 1'b0;
      rx_int    <= 1'b0;
      bufna_int <= 1'b0;
      miss_cnt  <= '0;
    end else begin
      state_q   <= state_d;
      stalled_q <= stalled_d;
      rx_int    <= rx_int_d;
      bufna_int <= bufna_d;
      if (store) begin
        boff_q  <= boff_d;
        flen_q  <= flen_d;
        first_q <= first_d;
      end
      if (desc_we) ptr_q <= ptr_d;
      if (miss_inc && miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
    end
  end

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> !own_vec[$past(desc_idx)]); // R2
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> ptr_q != $past(ptr_q)); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_we |=> $stable(ptr_q)); // R6
  AST_STALL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled_q && !poll && state_q == FS_IDLE) |-> !buf_we); // R9
  AST_MISS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> miss_cnt >= $past(miss_cnt)); // R9
  AST_BUFNA_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    bufna_int |-> stalled_q); // R10
endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer import rxr_pkg::*; #(
  parameter int NUM_DESC  = 4,
  parameter int BUF_BYTES = 1536,
  parameter int MISS_W    = 16,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int BUF_WORDS = BUF_BYTES / 4,
  localparam int MEM_WORDS = NUM_DESC * BUF_WORDS,
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int BOFF_W    = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  input  logic [ERR_W-1:0]   rx_err,
  input  logic [MATCH_W-1:0] rx_match,
  input  logic               poll,
  input  logic               host_req,
  input  logic               host_we,
  input  logic               host_dsel,
  input  logic [AW-1:0]      host_addr,
  input  logic [DESC_W-1:0]  host_wdata,
  output logic [DESC_W-1:0]  host_rdata,
  output logic               rx_int,
  output logic               bufna_int,
  output logic [MISS_W-1:0]  miss_cnt
);
  logic                rst_n_s;
  logic                desc_we, buf_we;
  logic [IDX_W-1:0]    desc_idx;
  logic [DESC_W-1:0]   desc_wdata, desc_rd, desc_rd_q, buf_rd;
  logic [NUM_DESC-1:0] own_vec;
  logic [AW-1:0]       buf_addr;
  logic [1:0]          buf_lane;
  logic [7:0]          buf_byte;
  logic                host_rd, host_dwr, sel_q;
  logic                unused_addr_hi;

  assign host_rd        = host_req && !host_we;
  assign host_dwr       = host_req && host_we && host_dsel;
  assign unused_addr_hi = &{1'b0, host_addr[AW-1:IDX_W]};

  rxr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rxr_desc_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .eng_we     (desc_we),
    .eng_idx    (desc_idx),
    .eng_wdata  (desc_wdata),
    .host_we    (host_dwr),
    .host_idx   (host_addr[IDX_W-1:0]),
    .host_wdata (host_wdata),
    .rd_idx     (host_addr[IDX_W-1:0]),
    .rd_data    (desc_rd),
    .own_vec    (own_vec)
  );

  rxr_buf_mem #(.DEPTH(MEM_WORDS), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (buf_we),
    .wr_addr (buf_addr),
    .wr_lane (buf_lane),
    .wr_byte (buf_byte),
    .rd_en   (host_rd && !host_dsel),
    .rd_addr (host_addr),
    .rd_data (buf_rd)
  );

  rxr_fill_ctrl #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES),
    .BOFF_W(BOFF_W), .AW(AW), .MISS_W(MISS_W)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_err     (rx_err),
    .rx_match   (rx_match),
    .poll       (poll),
    .own_vec    (own_vec),
    .desc_we    (desc_we),
    .desc_idx   (desc_idx),
    .desc_wdata (desc_wdata),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .buf_lane   (buf_lane),
    .buf_byte   (buf_byte),
    .rx_int     (rx_int),
    .bufna_int  (bufna_int),
    .miss_cnt   (miss_cnt)
  );

  // host read path: one register stage for descriptor words, select held with it
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      desc_rd_q <= '0;
      sel_q     <= 1'b1;
    end else if (host_rd) begin
      sel_q <= host_dsel;
      if (host_dsel) desc_rd_q <= desc_rd;
    end
  end

  assign host_rdata = sel_q ? desc_rd_q : buf_rd;
endmodule

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, poll = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [4:0]  rx_err = '0;
  logic [2:0]  rx_match = '0;
  logic        host_req = 1'b0, host_we = 1'b0, host_dsel = 1'b0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        rx_int, bufna_int;
  logic [15:0] miss_cnt;

  int total = 0, fails = 0, rxint_cnt = 0, bufna_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_match(rx_match), .poll(poll),
    .host_req(host_req), .host_we(host_we), .host_dsel(host_dsel),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_int(rx_int), .bufna_int(bufna_int), .miss_cnt(miss_cnt)
  );

  always @(negedge clk) begin
    if (rx_int)    rxint_cnt++;
    if (bufna_int) bufna_cnt++;
  end

  function automatic logic [7:0] bv(int seed, int k);
    return 8'(seed + k * 3 + k / 256);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(bit dsel, int addr, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_dsel = dsel; host_addr = 11'(addr);
    @(negedge clk);
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic wr(bit dsel, int addr, logic [31:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_dsel = dsel; host_addr = 11'(addr); host_wdata = v;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic give(int idx);
    wr(1'b1, idx, 32'h8000_0000);
  endtask

  task automatic chk_desc(string tag, int idx, logic [31:0] exp);
    logic [31:0] d;
    rd(1'b1, idx, d);
    chk(tag, d, exp);
  endtask

  // compare nbytes of a descriptor buffer with frame bytes starting at frame index base
  task automatic chk_buf(string tag, int idx, int base, int nbytes, int seed);
    logic [31:0] d;
    int bad = 0;
    logic [31:0] first_act = '0, first_exp = '0;
    for (int w = 0; w < (nbytes + 3) / 4; w++) begin
      rd(1'b0, idx * 384 + w, d);
      for (int l = 0; l < 4; l++) begin
        if (w * 4 + l < nbytes && d[8*l +: 8] !== bv(seed, base + w * 4 + l)) begin
          if (bad == 0) begin first_act = d; first_exp = {24'h0, bv(seed, base + w * 4 + l)}; end
          bad++;
        end
      end
    end
    total++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: got %h expected %h (%0d bytes differ)", tag, first_act, first_exp, bad);
    end
  endtask

  task automatic send_frame(int len, int seed, logic [4:0] err, logic [2:0] match,
                            bit poll_first, bit collide);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = bv(seed, k);
      rx_last  = (k == len - 1);
      rx_err   = (k == len - 1) ? err : 5'h0;
      rx_match = (k == len - 1) ? match : 3'h0;
      poll     = poll_first && (k == 0);
      if (collide && k == len - 1) begin
        host_req = 1'b1; host_we = 1'b1; host_dsel = 1'b1;
        host_addr = 11'd1; host_wdata = 32'h8000_1234;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; poll = 1'b0; host_req = 1'b0; host_we = 1'b0;
    rx_err = '0; rx_match = '0;
    @(negedge clk);
  endtask

  task automatic pulse_poll;
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rdata", host_rdata, 32'h0);
    chk("R1 rx_int", {31'h0, rx_int}, 32'h0);
    chk("R1 bufna", {31'h0, bufna_int}, 32'h0);
    chk("R1 miss", {16'h0, miss_cnt}, 32'h0);
    for (int i = 0; i < 4; i++) chk_desc("R1 desc", i, 32'h0);
  endtask

  task automatic t_unowned;
    int b0 = bufna_cnt, r0 = rxint_cnt;
    send_frame(10, 5, 5'h0, 3'h0, 1'b0, 1'b0);
    chk("R9 miss after drop", {16'h0, miss_cnt}, 32'd1);
    chk("R10 bufna on stall", 32'(bufna_cnt - b0), 32'd1);
    chk("R9 no rx_int", 32'(rxint_cnt - r0), 32'd0);
    chk_desc("R9 desc untouched", 0, 32'h0);
    pulse_poll();
    chk("R10 poll unowned bufna", 32'(bufna_cnt - b0), 32'd2);
    give(0);
    send_frame(12, 9, 5'h0, 3'h0, 1'b0, 1'b0);
    chk("R9 stalled drop miss", {16'h0, miss_cnt}, 32'd2);
    chk("R10 no repeat bufna", 32'(bufna_cnt - b0), 32'd2);
    chk_desc("R9 returned desc kept", 0, 32'h8000_0000);
    pulse_poll();
    chk("R10 resume no bufna", 32'(bufna_cnt - b0), 32'd2);
  endtask

  task automatic t_single;
    int r0 = rxint_cnt;
    send_frame(64, 17, 5'h0, 3'b010, 1'b0, 1'b0);
    chk("R8 rx_int once", 32'(rxint_cnt - r0), 32'd1);
    chk_desc("R3 R4 single status", 0, 32'h0040_2C00);
    chk_buf("R2 payload", 0, 0, 64, 17);
  endtask

  task automatic t_errors;
    give(1);
    send_frame(23, 40, 5'b01010, 3'b101, 1'b0, 1'b0);
    chk_desc("R5 R4 error status", 1, 32'h0017_5CA8);
    chk_buf("R2 payload d1", 1, 0, 23, 40);
  endtask

  task automatic t_wrap;
    give(2); give(3); give(0);
    send_frame(10, 1, 5'h0, 3'h0, 1'b0, 1'b0);
    send_frame(11, 2, 5'h0, 3'h0, 1'b0, 1'b0);
    send_frame(12, 3, 5'h0, 3'h0, 1'b0, 1'b0);
    chk_desc("R6 order d2", 2, 32'h000A_0C00);
    chk_desc("R6 order d3", 3, 32'h000B_0C00);
    chk_desc("R6 wrap d0", 0, 32'h000C_0C00);
    chk_buf("R6 wrap payload", 0, 0, 12, 3);
  endtask

  task automatic t_poll_running;
    int b0 = bufna_cnt;
    logic [15:0] m0 = miss_cnt;
    pulse_poll();
    chk("R10 poll running bufna", 32'(bufna_cnt - b0), 32'd0);
    chk("R10 poll running miss", {16'h0, miss_cnt}, {16'h0, m0});
  endtask

  task automatic t_span;
    int r0 = rxint_cnt;
    give(1); give(2);
    send_frame(1600, 77, 5'h0, 3'b001, 1'b0, 1'b0);
    chk("R8 one rx_int for span", 32'(rxint_cnt - r0), 32'd1);
    chk_desc("R7 first part", 1, 32'h0600_0800);
    chk_desc("R7 last part", 2, 32'h0640_1400);
    chk_buf("R7 part one bytes", 1, 0, 1536, 77);
    chk_buf("R7 part two bytes", 2, 1536, 64, 77);
  endtask

  task automatic t_cross;
    int b0 = bufna_cnt, r0 = rxint_cnt;
    logic [15:0] m0 = miss_cnt;
    give(3);
    send_frame(1540, 90, 5'h0, 3'h0, 1'b0, 1'b0);
    chk_desc("R12 filled non-last", 3, 32'h0600_0800);
    chk_desc("R12 next untouched", 0, 32'h000C_0C00);
    chk("R12 miss", {16'h0, miss_cnt}, {16'h0, m0 + 16'd1});
    chk("R12 bufna", 32'(bufna_cnt - b0), 32'd1);
    chk("R12 no rx_int", 32'(rxint_cnt - r0), 32'd0);
  endtask

  task automatic t_poll_same;
    int b0 = bufna_cnt;
    logic [15:0] m0 = miss_cnt;
    give(0);
    send_frame(20, 123, 5'h0, 3'h0, 1'b1, 1'b0);
    chk_desc("R11 stored with poll", 0, 32'h0014_0C00);
    chk("R11 no miss", {16'h0, miss_cnt}, {16'h0, m0});
    chk("R11 no bufna", 32'(bufna_cnt - b0), 32'd0);
    chk_buf("R11 payload", 0, 0, 20, 123);
  endtask

  task automatic t_collide;
    give(1);
    send_frame(8, 55, 5'h0, 3'h0, 1'b0, 1'b1);
    chk_desc("R14 engine wins", 1, 32'h0008_0C00);
  endtask

  task automatic t_host_buf;
    logic [31:0] d;
    wr(1'b0, 0, 32'hDEAD_BEEF);
    rd(1'b0, 0, d);
    chk("R13 buffer write ignored", d,
        {bv(123, 3), bv(123, 2), bv(123, 1), bv(123, 0)});
    wr(1'b1, 2, 32'h8000_00A5);
    chk_desc("R13 desc write readback", 2, 32'h8000_00A5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unowned();
    t_single();
    t_errors();
    t_wrap();
    t_poll_running();
    t_span();
    t_cross();
    t_poll_same();
    t_collide();
    t_host_buf();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule